// File: doc/BRIEF.md
# Raster Timing and Vertical-Blank Status

This block is the beat generator of a tile-based video pipeline. It runs on the pixel clock and keeps two counters, a cycle position inside the current line and a line number inside the current frame. From them it derives a visible-area indicator for the pixel pipeline and a one-cycle mark at the start of horizontal blanking, so that scroll logic knows when to reload its counters. The frame has a fixed visible height. It is followed by a blanking period whose length is picked by a region input: a short one for 60 Hz displays and a long one for 50 Hz displays.

The block also owns the vertical-blank status flag that the CPU reads through the status register. The flag is raised when the first blanking line begins and dropped when the frame wraps. Any status read clears it. A read that falls exactly on the cycle in which the flag would rise returns zero and prevents the flag from rising for that frame. An active-low interrupt line follows the flag, gated by the enable bit from the control register. If the CPU turns the enable on while the flag is still up, the interrupt is raised on the next cycle.

Top module: `raster_timing`

## Requirements
- R1: While reset is asserted, `cycle_o` and `line_o` are 0, `stat_vblank_o` is 0 and `nmi_n_o` is 1.
- R2: `cycle_o` advances by one each clock from 0 up to LINE_CYCLES-1 (default 341 cycles per line) and then returns to 0.
- R3: `line_o` advances when `cycle_o` wraps. It returns to 0 after line VIS_LINES+VBL_LINES_60-1 when `region_50` is 0 (default 260 lines), and after line VIS_LINES+VBL_LINES_50-1 when `region_50` is 1 (default 310 lines). `region_50` is sampled in the last cycle of a line. If the line number is already past the last line of the selected mode, the count wraps at the end of the current line.
- R4: `visible_o` is 1 exactly when `line_o` < VIS_LINES (default 240) and `cycle_o` < VIS_CYCLES (default 256).
- R5: `hmark_o` is 1 exactly in the cycle where `cycle_o` equals VIS_CYCLES.
- R6: When line VIS_LINES, cycle 0 is presented without a status read, `stat_vblank_o` reads 1 from the next cycle on. The flag reads 0 again in the cycle where the counters show line 0, cycle 0.
- R7: A cycle with `status_rd` high shows the current flag on `stat_vblank_o`, and the flag reads 0 in the following cycle.
- R8: If `status_rd` is high in the cycle that shows line VIS_LINES, cycle 0, then `stat_vblank_o` is 0 in that cycle and stays 0 until the frame wraps.
- R9: `nmi_n_o` is 0 in a cycle exactly when `stat_vblank_o` is 1 in that cycle and `nmi_en` was 1 in the previous cycle. When `nmi_en` is already 1, the interrupt falls in the same cycle the flag rises.
- R10: If `nmi_en` goes from 0 to 1 while the flag is set and no read or frame wrap intervenes, `nmi_n_o` goes low in the next cycle. If `nmi_en` drops, `nmi_n_o` returns high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| region_50 | input | 1 | 1 selects the long (50 Hz) blanking, 0 the short (60 Hz) blanking |
| status_rd | input | 1 | One-cycle strobe: the CPU reads the status register |
| nmi_en | input | 1 | Interrupt-enable bit of the control register |
| cycle_o | output | CYC_W | Cycle position within the line |
| line_o | output | LINE_W | Line number within the frame |
| visible_o | output | 1 | Current position is a displayed pixel |
| hmark_o | output | 1 | Pulse at the first cycle after the visible pixels |
| stat_vblank_o | output | 1 | Vertical-blank flag returned as status bit 7 |
| nmi_n_o | output | 1 | Active-low frame interrupt |

## Verification
The hardest situation to reach from the ports is a status read that lands exactly on the single cycle that raises the flag. Random reads almost never hit it, and the rest of that frame must then be watched to confirm that the flag never rises. The stimulus therefore tracks the raster position in the bench's own model and drives the read strobe on that exact cycle in a directed frame. Random frames follow, with reads that land on it only by chance. A second hard case is turning the interrupt enable on while the flag is held up. To reach it, a directed frame keeps the enable low through the rising edge of the flag, raises the enable a few cycles later, and only then reads the status.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Registered state of the blanking status logic
    typedef struct packed {
        logic flag;  // vertical-blank flag as seen by the CPU
        logic irq;   // interrupt request, active high internally
    } vbl_state_t;

    // Region select encoding
    typedef enum logic {
        REGION_60HZ = 1'b0,
        REGION_50HZ = 1'b1
    } region_e;

    // Larger of two blanking lengths, used to size the line counter
    function automatic int max_blank(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
    parameter int LINE_CYCLES  = 341,
    parameter int VIS_CYCLES   = 256,
    parameter int VIS_LINES    = 240,
    parameter int VBL_LINES_60 = 20,
    parameter int VBL_LINES_50 = 70,
    parameter int CYC_W        = 9,
    parameter int LINE_W       = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              region_50,
    output logic [CYC_W-1:0]  cyc_o,
    output logic [LINE_W-1:0] line_o,
    output logic              visible_o,
    output logic              hmark_o,
    output logic              set_evt_o,
    output logic              frame_end_o
);
    import raster_pkg::*;

    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(LINE_CYCLES - 1);
    localparam logic [CYC_W-1:0]  CYC_HBLK  = CYC_W'(VIS_CYCLES);
    localparam logic [LINE_W-1:0] LINE_VBLK = LINE_W'(VIS_LINES);
    localparam logic [LINE_W-1:0] LAST_60   = LINE_W'(VIS_LINES + VBL_LINES_60 - 1);
    localparam logic [LINE_W-1:0] LAST_50   = LINE_W'(VIS_LINES + VBL_LINES_50 - 1);

    typedef struct packed {
        logic [CYC_W-1:0]  cyc;
        logic [LINE_W-1:0] line;
    } pos_t;

    pos_t              pos_d, pos_q;
    logic [LINE_W-1:0] last_line;
    logic              line_end;

    always_comb begin
        last_line = (region_e'(region_50) == REGION_50HZ) ? LAST_50 : LAST_60;
        line_end  = (pos_q.cyc == CYC_LAST);
        pos_d     = pos_q;
        if (line_end) begin
            pos_d.cyc = '0;
            if (pos_q.line >= last_line) begin
                pos_d.line = '0;
            end else begin
                pos_d.line = pos_q.line + 1'b1;
            end
        end else begin
            pos_d.cyc = pos_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign cyc_o       = pos_q.cyc;
    assign line_o      = pos_q.line;
    assign visible_o   = (pos_q.line < LINE_VBLK) && (pos_q.cyc < CYC_HBLK);
    assign hmark_o     = (pos_q.cyc == CYC_HBLK);
    assign set_evt_o   = (pos_q.line == LINE_VBLK) && (pos_q.cyc == '0);
    assign frame_end_o = line_end && (pos_q.line >= last_line);

endmodule

// File: rtl/vblank_status.sv
module vblank_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic frame_end,
    input  logic status_rd,
    input  logic nmi_en,
    output logic flag_o,
    output logic nmi_n_o
);
    import raster_pkg::*;

    vbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_end) begin
            st_d.flag = 1'b0;
        end else if (set_evt) begin
            // a read landing on the raising cycle wins and keeps the flag low
            st_d.flag = !status_rd;
        end else if (status_rd) begin
            st_d.flag = 1'b0;
        end
        st_d.irq = st_d.flag && nmi_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o  = st_q.flag;
    assign nmi_n_o = !st_q.irq;

endmodule

// File: rtl/raster_timing.sv
module raster_timing #(
    parameter int LINE_CYCLES  = 341,
    parameter int VIS_CYCLES   = 256,
    parameter int VIS_LINES    = 240,
    parameter int VBL_LINES_60 = 20,
    parameter int VBL_LINES_50 = 70,
    localparam int CYC_W  = $clog2(LINE_CYCLES),
    localparam int LINE_W = $clog2(VIS_LINES + raster_pkg::max_blank(VBL_LINES_60, VBL_LINES_50))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              region_50,
    input  logic              status_rd,
    input  logic              nmi_en,
    output logic [CYC_W-1:0]  cycle_o,
    output logic [LINE_W-1:0] line_o,
    output logic              visible_o,
    output logic              hmark_o,
    output logic              stat_vblank_o,
    output logic              nmi_n_o
);

    logic set_evt;
    logic frame_end;

    raster_counter #(
        .LINE_CYCLES (LINE_CYCLES),
        .VIS_CYCLES  (VIS_CYCLES),
        .VIS_LINES   (VIS_LINES),
        .VBL_LINES_60(VBL_LINES_60),
        .VBL_LINES_50(VBL_LINES_50),
        .CYC_W       (CYC_W),
        .LINE_W      (LINE_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .region_50  (region_50),
        .cyc_o      (cycle_o),
        .line_o     (line_o),
        .visible_o  (visible_o),
        .hmark_o    (hmark_o),
        .set_evt_o  (set_evt),
        .frame_end_o(frame_end)
    );

    vblank_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (set_evt),
        .frame_end(frame_end),
        .status_rd(status_rd),
        .nmi_en   (nmi_en),
        .flag_o   (stat_vblank_o),
        .nmi_n_o  (nmi_n_o)
    );

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
    parameter int LINE_CYCLES  = 341,
    parameter int VIS_LINES    = 240,
    parameter int VBL_LINES_50 = 70,
    parameter int CYC_W        = 9,
    parameter int LINE_W       = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              status_rd,
    input logic              nmi_en,
    input logic [CYC_W-1:0]  cycle_o,
    input logic [LINE_W-1:0] line_o,
    input logic              stat_vblank_o,
    input logic              nmi_n_o
);
    localparam logic [CYC_W-1:0]  C_LAST  = CYC_W'(LINE_CYCLES - 1);
    localparam logic [LINE_W-1:0] L_VBLK  = LINE_W'(VIS_LINES);
    localparam logic [LINE_W-1:0] L_MAX   = LINE_W'(VIS_LINES + VBL_LINES_50 - 1);

    // R1: outputs held at their idle values during reset
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_state_R1: assert (cycle_o == '0 && line_o == '0 && !stat_vblank_o && nmi_n_o)
                else $error("reset state wrong");
        end
    end

    assert_cycle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_o != C_LAST) |=> (cycle_o == $past(cycle_o) + 1'b1));

    assert_cycle_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_o == C_LAST) |=> (cycle_o == '0));

    assert_line_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_o == C_LAST && line_o >= L_MAX) |=> (line_o == '0));

    assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o == L_VBLK && cycle_o == '0 && !status_rd) |=> stat_vblank_o);

    assert_frame_start_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o == '0 && cycle_o == '0) |-> !stat_vblank_o);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> !stat_vblank_o);

    assert_race_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o == L_VBLK && cycle_o == '0 && status_rd) |=> !stat_vblank_o);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_n_o |-> stat_vblank_o);

    assert_late_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vblank_o && nmi_en && !status_rd && cycle_o != C_LAST) |=> !nmi_n_o);

    assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_en |=> nmi_n_o);

endmodule

bind raster_timing raster_timing_chk #(
    .LINE_CYCLES (LINE_CYCLES),
    .VIS_LINES   (VIS_LINES),
    .VBL_LINES_50(VBL_LINES_50),
    .CYC_W       (CYC_W),
    .LINE_W      (LINE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .status_rd    (status_rd),
    .nmi_en       (nmi_en),
    .cycle_o      (cycle_o),
    .line_o       (line_o),
    .stat_vblank_o(stat_vblank_o),
    .nmi_n_o      (nmi_n_o)
);

// File: tb/raster_timing_test.sv
module raster_timing_test;
    localparam int LC  = 48;
    localparam int VC  = 32;
    localparam int VL  = 16;
    localparam int B60 = 3;
    localparam int B50 = 6;
    localparam int CW  = $clog2(LC);
    localparam int LW  = $clog2(VL + B50);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          region_50 = 1'b0;
    logic          status_rd = 1'b0;
    logic          nmi_en = 1'b0;
    logic [CW-1:0] cycle_o;
    logic [LW-1:0] line_o;
    logic          visible_o, hmark_o, stat_vblank_o, nmi_n_o;

    raster_timing #(
        .LINE_CYCLES(LC), .VIS_CYCLES(VC), .VIS_LINES(VL),
        .VBL_LINES_60(B60), .VBL_LINES_50(B50)
    ) uut (
        .clk(clk), .rst_n(rst_n), .region_50(region_50),
        .status_rd(status_rd), .nmi_en(nmi_en),
        .cycle_o(cycle_o), .line_o(line_o), .visible_o(visible_o),
        .hmark_o(hmark_o), .stat_vblank_o(stat_vblank_o), .nmi_n_o(nmi_n_o)
    );

    always #5 clk = ~clk;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    // bench model of the raster position and status
    int  m_cyc = 0, m_line = 0;
    bit  m_flag = 0, m_irq = 0;
    bit  supp_frame = 0, rd_prev = 0, en_prev = 0, en_chg = 0, reg_chg = 0, reg_prev = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (model line %0d cycle %0d)",
                     tag, act, exp, m_line, m_cyc);
        end
    endtask

    task automatic compare();
        chk("R2 cycle", int'(cycle_o), m_cyc);
        chk(reg_chg ? "R3 line after region change" : "R3 line", int'(line_o), m_line);
        chk("R4 visible", int'(visible_o), int'(m_line < VL && m_cyc < VC));
        chk("R5 hmark", int'(hmark_o), int'(m_cyc == VC));
        chk(supp_frame ? "R8 flag suppressed" : (rd_prev ? "R7 flag after read" : "R6 flag"),
            int'(stat_vblank_o), int'(m_flag));
        chk(en_chg ? "R10 nmi after enable change" : "R9 nmi", int'(nmi_n_o), int'(!m_irq));
    endtask

    // called at a falling edge: check, drive, advance one clock, update model
    task automatic step(input bit rd, input bit en, input bit r50);
        int  last;
        bit  fend, setc, nf;
        compare();
        status_rd = rd; nmi_en = en; region_50 = r50;
        @(posedge clk);
        last = r50 ? (VL + B50 - 1) : (VL + B60 - 1);
        fend = (m_cyc == LC - 1) && (m_line >= last);
        setc = (m_line == VL) && (m_cyc == 0);
        if (fend)      nf = 0;
        else if (setc) nf = !rd;
        else if (rd)   nf = 0;
        else           nf = m_flag;
        if (setc && rd) supp_frame = 1;
        if (fend)       supp_frame = 0;
        m_irq   = nf && en;
        m_flag  = nf;
        rd_prev = rd;
        en_chg  = (en != en_prev);
        en_prev = en;
        reg_chg = (r50 != reg_prev);
        reg_prev = r50;
        if (m_cyc == LC - 1) begin
            m_cyc  = 0;
            m_line = fend ? 0 : m_line + 1;
        end else begin
            m_cyc = m_cyc + 1;
        end
        @(negedge clk);
    endtask

    function automatic bit at_origin();
        return (m_line == 0) && (m_cyc == 0);
    endfunction

    initial begin
        int unsigned seed_val;
        bit rr, ee, gg;
        seed_val = $urandom(32'd20240611);
        // reset state, R1
        repeat (3) @(negedge clk);
        chk("R1 reset cycle", int'(cycle_o), 0);
        chk("R1 reset line", int'(line_o), 0);
        chk("R1 reset flag", int'(stat_vblank_o), 0);
        chk("R1 reset nmi", int'(nmi_n_o), 1);
        rst_n = 1'b1;

        // frame A: 60 Hz, enable held high, no reads (R6 rise and wrap clear, R9)
        do step(1'b0, 1'b1, 1'b0); while (!at_origin());

        // frame B: 50 Hz, enable raised late while flag set (R10), then read (R7)
        do begin
            ee = (m_line > VL + 1) || (m_line == VL + 1 && m_cyc >= 5);
            rr = (m_line == VL + 2) && (m_cyc == 0);
            step(rr, ee, 1'b1);
        end while (!at_origin());

        // frame C: 60 Hz, read exactly on the raising cycle (R8)
        do begin
            rr = (m_line == VL) && (m_cyc == 0);
            step(rr, 1'b1, 1'b0);
        end while (!at_origin());

        // frame D: 50 Hz until past the 60 Hz last line, then switch (R3)
        do begin
            gg = !(m_line >= VL + 4);
            step(1'b0, 1'b1, gg);
        end while (!at_origin());

        // random frames
        gg = 1'b0; ee = 1'b1;
        for (int f = 0; f < 50; f++) begin
            int mode;
            gg   = $urandom_range(1, 0) == 1;
            mode = $urandom_range(3, 0);
            do begin
                if ($urandom_range(39, 0) == 0) ee = !ee;
                if ($urandom_range(599, 0) == 0) gg = !gg;
                case (mode)
                    0: rr = 1'b0;
                    1: rr = $urandom_range(63, 0) == 0;
                    2: rr = (m_line == VL) && (m_cyc == 0);
                    default: rr = (m_line >= VL) && ($urandom_range(199, 0) == 0);
                endcase
                step(rr, ee, gg);
            end while (!at_origin());
        end
        compare();

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule